// File: doc/BRIEF.md
# PS/2 Mouse to Quadrature Emulator

This block lets a machine that reads a raw ball mouse (two quadrature encoders and one button) work with a modern serial mouse. It sits behind an external PS/2 transceiver that supplies a byte interface. After reset it sends the stream-enable command byte and then ignores all traffic until the mouse returns its acknowledge byte. From then on it assembles three-byte movement packets, and turns each signed X/Y delta back into timed quadrature waveforms. A delta of N produces N full four-state cycles, and the sign of the delta sets the phase order.

Each axis has an accumulator for pending quarter-steps, so a new packet that arrives while earlier movement is still being emitted adds to that movement and nothing is lost. Phase steps are paced by a shared programmable divider, which keeps the edge rate low enough for the host's interrupt handler. The leading phase of each axis raises a level-2 interrupt request on every transition. The request stays set until the host acknowledges it. The trailing phases and the button are plain levels.

Top module: `ps2q_top`

## Requirements
- R1: After reset, `tx_valid_o` is 1 with `tx_data_o` = 8'hF4, and both hold until a cycle with `tx_ready_i` = 1. From the cycle after that handshake, `tx_valid_o` is 0 and stays 0 until the next reset.
- R2: Before a received byte equal to ACK_BYTE (default 8'hFA) arrives, every received byte is discarded. A different byte, such as 8'hFE, does not end the wait. Discarded packets move no quadrature line and leave `btn_o` unchanged.
- R3: A packet starts only with a byte whose bit 3 is 1. Any other byte in the first position is dropped. In the first byte, bit 0 is left, bit 1 is right, bit 2 is middle, bit 4 is the X sign and bit 5 is the Y sign. The second byte holds the low 8 bits of the X delta and the third byte holds the low 8 bits of the Y delta, giving a 9-bit two's-complement delta per axis.
- R4: A positive delta N moves an axis through 4N steps in the order (a,b) = 00, 10, 11, 01, 00. Exactly one line of the axis changes per step.
- R5: A negative delta -N moves an axis through 4N steps in the reverse order 00, 01, 11, 10, 00.
- R6: A delta that arrives while earlier steps are still pending is added to them. The net movement of the axis equals the sum of all its deltas.
- R7: Two consecutive steps of one axis are at least `div_i`+1 clock cycles apart.
- R8: Any change of `x_a_o` or `y_a_o` sets `irq_o`. `irq_o` then stays 1 until a cycle with `irq_ack_i` = 1 and no new change, and is 0 after that cycle. `ipl_o` is 3'd2 while `irq_o` is 1 and 3'd0 otherwise.
- R9: Changes of `x_b_o`, `y_b_o` or `btn_o` alone do not set `irq_o`. `btn_o` is the OR of the three button bits of the most recent packet.
- R10: In reset, all four quadrature lines, `btn_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Byte received from mouse is valid this cycle |
| rx_data_i | input | 8 | Received byte |
| tx_ready_i | input | 1 | Transceiver accepts the byte being offered |
| tx_valid_o | output | 1 | Command byte offered to transceiver |
| tx_data_o | output | 8 | Command byte |
| div_i | input | DIV_W | Step pacing: one step per div_i+1 cycles |
| irq_ack_i | input | 1 | Clears the interrupt request |
| x_a_o | output | 1 | X leading phase (interrupting) |
| x_b_o | output | 1 | X trailing phase (level) |
| y_a_o | output | 1 | Y leading phase (interrupting) |
| y_b_o | output | 1 | Y trailing phase (level) |
| btn_o | output | 1 | Button level, 1 = pressed |
| irq_o | output | 1 | Interrupt request |
| ipl_o | output | 3 | Interrupt priority level, 2 when requesting |

## Verification
The hardest condition to reach is a step on a trailing phase while an interrupt is visible and already acknowledged. At that moment a wrongly wired request would fire on the B line. To make it observable, the bench sets the divider to 200 cycles, so each step stands alone. It waits for the leading-phase edge, acknowledges, and then checks the request line just after the trailing-phase edge. Accumulation is exercised with two back-to-back packets of opposite sign while the first is still stepping. The wait for the acknowledge byte is probed with a full packet and a non-acknowledge byte sent before it.

// File: rtl/ps2q_pkg.sv
package ps2q_pkg;
  localparam logic [7:0] CMD_STREAM = 8'hF4;
  localparam int HDR_SYNC = 3;
  localparam int HDR_XS   = 4;
  localparam int HDR_YS   = 5;

  typedef enum logic [1:0] {IN_CMD, IN_ACK, IN_RUN} init_st_e;

  typedef struct packed {
    logic [2:0] btn;
    logic [8:0] dx;
    logic [8:0] dy;
  } pkt_t;
endpackage

// File: rtl/ps2q_init.sv
module ps2q_init
  import ps2q_pkg::*;
#(
  parameter logic [7:0] ACK_BYTE = 8'hFA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       tx_ready_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       run_o
);
  init_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= IN_CMD;
    else begin
      unique case (st_q)
        IN_CMD: if (tx_ready_i) st_q <= IN_ACK;
        IN_ACK: if (rx_valid_i && rx_data_i == ACK_BYTE) st_q <= IN_RUN;
        default: st_q <= IN_RUN;
      endcase
    end
  end

  assign tx_valid_o = (st_q == IN_CMD);
  assign tx_data_o  = (st_q == IN_CMD) ? CMD_STREAM : 8'h00;
  assign run_o      = (st_q == IN_RUN);
endmodule

// File: rtl/ps2q_parse.sv
module ps2q_parse
  import ps2q_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  output logic       pkt_valid_o,
  output pkt_t       pkt_o
);
  logic [1:0] idx_q;
  logic [7:0] hdr_q, xlo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= 2'd0;
      hdr_q       <= 8'h00;
      xlo_q       <= 8'h00;
      pkt_valid_o <= 1'b0;
      pkt_o       <= '0;
    end else begin
      pkt_valid_o <= 1'b0;
      if (byte_valid_i) begin
        unique case (idx_q)
          2'd0: if (byte_i[HDR_SYNC]) begin  // resync on missing marker
            hdr_q <= byte_i;
            idx_q <= 2'd1;
          end
          2'd1: begin
            xlo_q <= byte_i;
            idx_q <= 2'd2;
          end
          default: begin
            pkt_o.btn   <= hdr_q[2:0];
            pkt_o.dx    <= {hdr_q[HDR_XS], xlo_q};
            pkt_o.dy    <= {hdr_q[HDR_YS], byte_i};
            pkt_valid_o <= 1'b1;
            idx_q       <= 2'd0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ps2q_div.sv
module ps2q_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ps2q_axis.sv
module ps2q_axis #(
  parameter int ACC_W = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [8:0] delta_i,
  input  logic       tick_i,
  output logic       a_o,
  output logic       b_o
);
  // pending movement kept in quarter-steps
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W:0]   add_w, stp_w, sum_w;
  logic signed [ACC_W-1:0] acc_d;
  logic                    move_w, pos_w, flip_a_w;

  assign move_w = tick_i && (acc_q != '0);
  assign pos_w  = !acc_q[ACC_W-1];

  always_comb begin
    add_w = load_i ? (ACC_W+1)'($signed({delta_i, 2'b00})) : '0;
    if (!move_w)    stp_w = '0;
    else if (pos_w) stp_w = '1;
    else            stp_w = (ACC_W+1)'(1);
    sum_w = (ACC_W+1)'(acc_q) + add_w + stp_w;
    if (sum_w[ACC_W] != sum_w[ACC_W-1])
      acc_d = sum_w[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else
      acc_d = sum_w[ACC_W-1:0];
  end

  // forward: equal lines -> flip a, else flip b; reverse swaps the roles
  assign flip_a_w = ((a_o == b_o) == pos_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      a_o   <= 1'b0;
      b_o   <= 1'b0;
    end else begin
      acc_q <= acc_d;
      if (move_w) begin
        if (flip_a_w) a_o <= ~a_o;
        else          b_o <= ~b_o;
      end
    end
  end
endmodule

// File: rtl/ps2q_irq.sv
module ps2q_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_a_i,
  input  logic y_a_i,
  input  logic ack_i,
  output logic irq_o
);
  logic x_q, y_q, chg_w;

  assign chg_w = (x_a_i != x_q) || (y_a_i != y_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= 1'b0;
      y_q   <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      x_q <= x_a_i;
      y_q <= y_a_i;
      if (chg_w)      irq_o <= 1'b1;
      else if (ack_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ps2q_top.sv
module ps2q_top
  import ps2q_pkg::*;
#(
  parameter int         DIV_W    = 16,
  parameter int         ACC_W    = 14,
  parameter logic [7:0] ACK_BYTE = 8'hFA,
  parameter logic [2:0] IRQ_LVL  = 3'd2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  input  logic [DIV_W-1:0] div_i,
  input  logic             irq_ack_i,
  output logic             x_a_o,
  output logic             x_b_o,
  output logic             y_a_o,
  output logic             y_b_o,
  output logic             btn_o,
  output logic             irq_o,
  output logic [2:0]       ipl_o
);
  localparam int N_AX = 2;

  logic       run_w, pkt_v_w, tick_w;
  pkt_t       pkt_w;
  logic [8:0] dl_w [N_AX];
  logic       ax_a [N_AX];
  logic       ax_b [N_AX];

  ps2q_init #(.ACK_BYTE(ACK_BYTE)) u_init (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .tx_ready_i,
    .tx_valid_o, .tx_data_o, .run_o(run_w)
  );

  ps2q_parse u_parse (
    .clk_i, .rst_ni,
    .byte_valid_i(rx_valid_i && run_w), .byte_i(rx_data_i),
    .pkt_valid_o(pkt_v_w), .pkt_o(pkt_w)
  );

  ps2q_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .div_i, .tick_o(tick_w)
  );

  assign dl_w[0] = pkt_w.dx;
  assign dl_w[1] = pkt_w.dy;

  for (genvar g = 0; g < N_AX; g++) begin : g_ax
    ps2q_axis #(.ACC_W(ACC_W)) u_axis (
      .clk_i, .rst_ni, .load_i(pkt_v_w), .delta_i(dl_w[g]),
      .tick_i(tick_w), .a_o(ax_a[g]), .b_o(ax_b[g])
    );
  end

  assign x_a_o = ax_a[0];
  assign x_b_o = ax_b[0];
  assign y_a_o = ax_a[1];
  assign y_b_o = ax_b[1];

  ps2q_irq u_irq (
    .clk_i, .rst_ni, .x_a_i(x_a_o), .y_a_i(y_a_o), .ack_i(irq_ack_i), .irq_o
  );

  assign ipl_o = irq_o ? IRQ_LVL : 3'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      btn_o <= 1'b0;
    else if (pkt_v_w) btn_o <= |pkt_w.btn;
  end
endmodule

// File: rtl/ps2q_chk.sv
module ps2q_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_ready_i,
  input logic             tx_valid_o,
  input logic [7:0]       tx_data_o,
  input logic [DIV_W-1:0] div_i,
  input logic             irq_ack_i,
  input logic             irq_o,
  input logic             x_a_o,
  input logic             x_b_o,
  input logic             y_a_o,
  input logic             y_b_o
);
  logic             px_a, px_b, py_a, py_b, xc, yc;
  logic [DIV_W:0]   gx_q, gy_q;

  assign xc = (x_a_o != px_a) || (x_b_o != px_b);
  assign yc = (y_a_o != py_a) || (y_b_o != py_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {px_a, px_b, py_a, py_b} <= '0;
      gx_q <= '1;
      gy_q <= '1;
    end else begin
      {px_a, px_b, py_a, py_b} <= {x_a_o, x_b_o, y_a_o, y_b_o};
      gx_q <= xc ? '0 : ((&gx_q) ? gx_q : gx_q + 1'b1);
      gy_q <= yc ? '0 : ((&gy_q) ? gy_q : gy_q + 1'b1);
    end
  end

  // R1
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && tx_data_o == 8'hF4);
  // R1
  cmd_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i) || !tx_valid_o |=> !tx_valid_o);
  // R4
  x_gray_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(x_a_o) && !$stable(x_b_o)));
  // R4
  y_gray_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(y_a_o) && !$stable(y_b_o)));
  // R7
  x_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xc |-> gx_q >= {1'b0, div_i});
  // R7
  y_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    yc |-> gy_q >= {1'b0, div_i});
  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_ack_i |=> irq_o);
  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(x_a_o) != $past(x_a_o, 2)) || ($past(y_a_o) != $past(y_a_o, 2)));
endmodule

bind ps2q_top ps2q_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/ps2q_top_bench.sv
module ps2q_top_bench;
  localparam int DIV_W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_valid_i = 1'b0, tx_ready_i = 1'b0, irq_ack_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic [DIV_W-1:0] div_i = 16'd1;
  logic tx_valid_o, x_a_o, x_b_o, y_a_o, y_b_o, btn_o, irq_o;
  logic [7:0] tx_data_o;
  logic [2:0] ipl_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ps2q_top u_ps2q_top (.*);

  // b0, b1, b2, expected dx, expected dy, expected button
  localparam logic [48:0] VEC [7] = '{
    {8'h08, 8'h03, 8'h00, 12'sd3,    12'sd0,    1'b0},
    {8'h28, 8'h05, 8'hFE, 12'sd5,    -12'sd2,   1'b0},
    {8'h19, 8'hFF, 8'h01, -12'sd1,   12'sd1,    1'b1},
    {8'h0A, 8'h00, 8'h00, 12'sd0,    12'sd0,    1'b1},
    {8'h0C, 8'h10, 8'h10, 12'sd16,   12'sd16,   1'b1},
    {8'h38, 8'h00, 8'h00, -12'sd256, -12'sd256, 1'b0},
    {8'h08, 8'hFF, 8'h80, 12'sd255,  12'sd128,  1'b0}
  };

  // quadrature monitor
  int net_x = 0, net_y = 0, bad = 0;
  int gap_cnt = 1000000, min_gap = 1000000, gen = 0, seen_gen = 0;
  logic pxa = 0, pxb = 0, pya = 0, pyb = 0;

  function automatic int qidx(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int qstep(input int o, input int n);
    int d;
    d = (n - o + 4) % 4;
    if (d == 1) return 1;
    if (d == 3) return -1;
    return 0;
  endfunction

  always @(negedge clk_i) begin
    if (gen != seen_gen) begin
      seen_gen = gen;
      min_gap = 1000000;
    end
    gap_cnt = gap_cnt + 1;
    if (rst_ni) begin
      if ({x_a_o, x_b_o} != {pxa, pxb}) begin
        if ((x_a_o != pxa) && (x_b_o != pxb)) bad = bad + 1;
        else net_x = net_x + qstep(qidx(pxa, pxb), qidx(x_a_o, x_b_o));
        if (gap_cnt < min_gap) min_gap = gap_cnt;
        gap_cnt = 0;
      end
      if ({y_a_o, y_b_o} != {pya, pyb}) begin
        if ((y_a_o != pya) && (y_b_o != pyb)) bad = bad + 1;
        else net_y = net_y + qstep(qidx(pya, pyb), qidx(y_a_o, y_b_o));
      end
    end
    {pxa, pxb, pya, pyb} = {x_a_o, x_b_o, y_a_o, y_b_o};
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk_i);
    rx_valid_i = 1'b1;
    rx_data_i  = b;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic pkt(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    send(b0); send(b1); send(b2);
  endtask

  task automatic ack_irq();
    @(negedge clk_i); irq_ack_i = 1'b1;
    @(negedge clk_i); irq_ack_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int sx, sy, sb;
    logic s;
    cyc(3);
    // R10 reset state
    chk("R10 quad lines", {x_a_o, x_b_o, y_a_o, y_b_o}, 0);
    chk("R10 btn/irq", {btn_o, irq_o}, 0);
    rst_ni = 1'b1;
    cyc(5);
    // R1 command offered and held
    chk("R1 tx_valid held", tx_valid_o, 1);
    chk("R1 tx_data", tx_data_o, 8'hF4);
    @(negedge clk_i); tx_ready_i = 1'b1;
    @(negedge clk_i); tx_ready_i = 1'b0;
    chk("R1 tx_valid after handshake", tx_valid_o, 0);
    cyc(3);
    chk("R1 tx_valid stays low", tx_valid_o, 0);

    // R2 traffic before acknowledge ignored
    sx = net_x;
    pkt(8'h09, 8'h04, 8'h00);
    send(8'hFE);
    pkt(8'h09, 8'h04, 8'h00);
    cyc(200);
    chk("R2 no movement before ack", net_x - sx, 0);
    chk("R2 button unchanged before ack", btn_o, 0);
    send(8'hFA);

    // R3 R4 R5 R9 table of packets
    div_i = 16'd1;
    foreach (VEC[i]) begin
      sx = net_x; sy = net_y; sb = bad;
      pkt(VEC[i][48:41], VEC[i][40:33], VEC[i][32:25]);
      cyc(2300);
      chk($sformatf("R3 R4 R5 x net vec%0d", i), net_x - sx, 4 * int'($signed(VEC[i][24:13])));
      chk($sformatf("R3 R4 R5 y net vec%0d", i), net_y - sy, 4 * int'($signed(VEC[i][12:1])));
      chk($sformatf("R9 btn vec%0d", i), btn_o, VEC[i][0]);
      chk($sformatf("R4 single-line steps vec%0d", i), bad - sb, 0);
    end

    // R3 header without sync bit dropped
    sx = net_x;
    send(8'h01);
    pkt(8'h08, 8'h02, 8'h00);
    cyc(200);
    chk("R3 resync after bad header", net_x - sx, 8);

    // R6 accumulation across packets
    div_i = 16'd3;
    sx = net_x;
    pkt(8'h08, 8'h03, 8'h00);
    pkt(8'h18, 8'hFF, 8'h00);
    cyc(300);
    chk("R6 accumulated net", net_x - sx, 8);

    // R7 spacing
    div_i = 16'd9;
    cyc(20);
    gen = gen + 1;
    pkt(8'h08, 8'h02, 8'h00);
    cyc(200);
    chk("R7 minimum step gap", (min_gap >= 10) ? 1 : 0, 1);

    // R8 R9 interrupt behaviour
    div_i = 16'd200;
    ack_irq();
    cyc(2);
    chk("R8 cleared before test", irq_o, 0);
    s = x_a_o;
    pkt(8'h08, 8'h01, 8'h00);
    for (int k = 0; k < 1000 && x_a_o == s; k++) @(negedge clk_i);
    cyc(3);
    chk("R8 irq on a edge", irq_o, 1);
    chk("R8 ipl level 2", ipl_o, 2);
    cyc(20);
    chk("R8 irq held", irq_o, 1);
    ack_irq();
    cyc(1);
    chk("R8 irq cleared by ack", irq_o, 0);
    chk("R8 ipl zero", ipl_o, 0);
    s = x_b_o;
    for (int k = 0; k < 1000 && x_b_o == s; k++) @(negedge clk_i);
    cyc(3);
    chk("R9 b edge gives no irq", irq_o, 0);
    cyc(900);
    ack_irq();
    cyc(2);
    send(8'h09); send(8'h00); send(8'h00);
    cyc(10);
    chk("R9 btn pressed", btn_o, 1);
    chk("R9 btn gives no irq", irq_o, 0);
    finish_run();
  end
endmodule